// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a 16-bit interval timer that runs from one timer clock. A prescaler divides the clock by a programmable ratio and produces a count pulse. A counter advances on each count pulse in one of three ways: upward, downward, or up and then down (center-aligned). Each time the counter completes an interval it raises an update event. The event sets a sticky flag and, when enabled, drives an interrupt request.

Software uses a small word-wide register port with a write strobe, a write address and a combinational read address. The period and divide values software writes are held in preload registers. The counter and prescaler copy them into their working copies only at the next update event, so a new period never cuts into the current interval.

Top module: `reload_timer`

## Requirements
- R1: A count pulse occurs once every (PSC + 1) timer clocks while enabled, so PSC = 0 counts on every clock and the update period in up mode is (RELOAD + 1) x (PSC + 1) clocks.
- R2: With mode field 0 (up), the counter steps 0, 1, ..., RELOAD, then returns to 0 with an update event on that wrap.
- R3: With mode field 1 (down), the counter steps down to 0 and on the next count pulse loads RELOAD with an update event, giving a period of RELOAD + 1 count pulses.
- R4: Mode fields 2, 3 and 4 count 0 up to RELOAD and back down to 0. The update event fires at the bottom turn (field 2), at the top turn (field 3) or at both (field 4); mode values 5 to 7 behave as up mode.
- R5: A write to RELOAD (address 4) reads back at once but governs the counter only from the next update event.
- R6: A write to PSC (address 3) reads back at once but changes the count-pulse spacing only from the next update event.
- R7: The update flag (STATUS address 2, bit 0) stays set until a write of 0 to that bit clears it; writing 1 has no effect.
- R8: When an update event and a flag-clearing write fall in the same clock, the flag ends set.
- R9: The interrupt request is high exactly while the flag is set and the enable bit (IEN address 1, bit 0) is 1.
- R10: While the run bit (CTRL address 0, bit 0) is 0 the counter and prescaler hold their values; CTRL bits 3:1 hold the mode field.
- R11: After reset every register, the counter (read at address 5) and the interrupt request are 0, and CTRL, IEN, PSC and RELOAD read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W (16) | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W (16) | Combinational read data |
| irq | output | 1 | Update interrupt request |

## Verification
The update event and a software write of 0 to the flag can land on the same clock edge. When that happens, setting takes priority over clearing. The bench provokes this in up mode with no prescaling by watching the counter at each falling edge. When it reads RELOAD there, it issues the clearing write for the very next rising edge, which is the wrap edge. After that edge it expects a zero count and a raised interrupt request. Just before this, it checks that a clearing write away from any update does lower the request, so the collision case is judged against a known clear.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

  localparam logic [2:0] MODE_UP       = 3'd0;
  localparam logic [2:0] MODE_DOWN     = 3'd1;
  localparam logic [2:0] MODE_CTR_BOT  = 3'd2;
  localparam logic [2:0] MODE_CTR_TOP  = 3'd3;
  localparam logic [2:0] MODE_CTR_BOTH = 3'd4;

  function automatic logic mode_is_center(input logic [2:0] m);
    return (m == MODE_CTR_BOT) || (m == MODE_CTR_TOP) || (m == MODE_CTR_BOTH);
  endfunction

  function automatic logic center_reports_top(input logic [2:0] m);
    return (m == MODE_CTR_TOP) || (m == MODE_CTR_BOTH);
  endfunction

  function automatic logic center_reports_bot(input logic [2:0] m);
    return (m == MODE_CTR_BOT) || (m == MODE_CTR_BOTH);
  endfunction

endpackage

// File: rtl/rtmr_regs.sv
module rtmr_regs
  import rtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [W-1:0]      cnt,
  input  logic              upd,
  output logic              run,
  output logic [2:0]        mode,
  output logic              ien,
  output logic              flag,
  output logic [W-1:0]      psc_pre,
  output logic [W-1:0]      reload_pre,
  output logic [W-1:0]      rd_data
);

  logic [3:0] ctrl_q;
  logic       clr_req;

  assign run     = ctrl_q[0];
  assign mode    = ctrl_q[3:1];
  assign clr_req = wr_en && (wr_addr == A_STATUS) && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ien        <= 1'b0;
      psc_pre    <= '0;
      reload_pre <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   ctrl_q     <= wr_data[3:0];
        A_IEN:    ien        <= wr_data[0];
        A_PSC:    psc_pre    <= wr_data;
        A_RELOAD: reload_pre <= wr_data;
        default:  ;
      endcase
    end
  end

  // set has priority over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (upd)     flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:   rd_data[3:0] = ctrl_q;
      A_IEN:    rd_data[0]   = ien;
      A_STATUS: rd_data[0]   = flag;
      A_PSC:    rd_data      = psc_pre;
      A_RELOAD: rd_data      = reload_pre;
      A_COUNT:  rd_data      = cnt;
      default:  rd_data      = '0;
    endcase
  end

endmodule

// File: rtl/rtmr_presc.sv
module rtmr_presc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         upd,
  input  logic [W-1:0] psc_pre,
  output logic         tick
);

  logic [W-1:0] psc_act_q;
  logic [W-1:0] div_q;

  assign tick = run && (div_q == psc_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act_q <= '0;
      div_q     <= '0;
    end else begin
      if (upd) psc_act_q <= psc_pre;
      if (upd)      div_q <= '0;
      else if (run) div_q <= tick ? '0 : div_q + W'(1);
    end
  end

endmodule

// File: rtl/rtmr_core.sv
module rtmr_core
  import rtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [W-1:0] reload_pre,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reload_act,
  output logic         upd
);

  logic dir_up_q;
  logic at_top, at_zero;
  logic top_turn, bot_turn;

  assign at_top  = (cnt >= reload_act);
  assign at_zero = (cnt == '0);

  always_comb begin
    top_turn = tick && dir_up_q && at_top;
    bot_turn = tick && !dir_up_q && at_zero;
    case (mode)
      MODE_DOWN: upd = tick && at_zero;
      MODE_CTR_BOT, MODE_CTR_TOP, MODE_CTR_BOTH:
        upd = (top_turn && center_reports_top(mode)) ||
              (bot_turn && center_reports_bot(mode));
      default:   upd = tick && at_top;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      reload_act <= '0;
      dir_up_q   <= 1'b1;
    end else begin
      if (upd) reload_act <= reload_pre;
      if (tick) begin
        if (mode_is_center(mode)) begin
          if (dir_up_q) begin
            if (at_top) begin
              dir_up_q <= 1'b0;
              cnt      <= (reload_act == '0) ? '0 : cnt - W'(1);
            end else begin
              cnt <= cnt + W'(1);
            end
          end else begin
            if (at_zero) begin
              dir_up_q <= 1'b1;
              cnt      <= (reload_act == '0) ? '0 : W'(1);
            end else begin
              cnt <= cnt - W'(1);
            end
          end
        end else if (mode == MODE_DOWN) begin
          dir_up_q <= 1'b1;
          cnt      <= at_zero ? reload_pre : cnt - W'(1);
        end else begin
          dir_up_q <= 1'b1;
          cnt      <= at_top ? '0 : cnt + W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              irq
);

  logic         run_w;
  logic [2:0]   mode_w;
  logic         ien_w;
  logic         flag_w;
  logic [W-1:0] psc_pre_w;
  logic [W-1:0] reload_pre_w;
  logic [W-1:0] reload_act_w;
  logic [W-1:0] cnt_w;
  logic         tick_w;
  logic         upd_w;

  rtmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt_w), .upd(upd_w),
    .run(run_w), .mode(mode_w), .ien(ien_w), .flag(flag_w),
    .psc_pre(psc_pre_w), .reload_pre(reload_pre_w), .rd_data(rd_data)
  );

  rtmr_presc #(.W(W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_w), .upd(upd_w),
    .psc_pre(psc_pre_w), .tick(tick_w)
  );

  rtmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .mode(mode_w),
    .reload_pre(reload_pre_w), .cnt(cnt_w), .reload_act(reload_act_w),
    .upd(upd_w)
  );

  assign irq = flag_w && ien_w;

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import rtmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic              irq,
  input logic              run,
  input logic [2:0]        mode,
  input logic              ien,
  input logic              flag,
  input logic              tick,
  input logic              upd,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      reload_act
);

  // R1
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R10
  count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UP && cnt >= reload_act) |=> (cnt == '0));

  // R3
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_DOWN && cnt == '0) |=> (cnt == reload_act));

  // R5
  reload_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(reload_act));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && wr_addr == A_STATUS && !wr_data[0])) |=> flag);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ien && !(wr_en && wr_addr == A_IEN)) |=> irq);

endmodule

bind reload_timer reload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .run(run_w), .mode(mode_w), .ien(ien_w),
  .flag(flag_w), .tick(tick_w), .upd(upd_w), .cnt(cnt_w),
  .reload_act(reload_act_w)
);

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  import rtmr_pkg::*;

  localparam int W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [W-1:0]      wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [W-1:0]      rd_data;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int c, prev;

  always #10 clk = ~clk;

  reload_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // caller is just after a falling edge
  task automatic wr_now(input logic [ADDR_W-1:0] a, input int d);
    wr_addr = a;
    wr_data = W'(d);
    wr_en   = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input int d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic samp();
    @(negedge clk);
    #1;
    prev = c;
    c = int'(rd_data);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int v);
    rd_addr = a;
    #1 v = int'(rd_data);
    rd_addr = A_COUNT;
  endtask

  task automatic start(input int psc, input int rl, input int md, input int ie);
    do_reset();
    wr(A_PSC, psc);
    wr(A_RELOAD, rl);
    wr(A_IEN, ie);
    wr(A_CTRL, (md << 1) | 1);
    rd_addr = A_COUNT;
    c = 0;
    prev = 0;
  endtask

  // length and peak of one full up-mode period
  task automatic measure_up(output int per, output int mx);
    per = 0;
    mx  = 0;
    for (int i = 0; i < 400; i++) begin
      samp();
      if (c == 0 && prev != 0) break;
    end
    for (int i = 0; i < 400; i++) begin
      samp();
      per++;
      if (c > mx) mx = c;
      if (c == 0 && prev != 0) break;
    end
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd(ADDR_W'(a), v);
      chk($sformatf("R11 reset addr %0d", a), v, 0);
    end
    chk("R11 reset irq", int'(irq), 0);
  endtask

  task automatic t_readback();
    int v;
    do_reset();
    wr(A_CTRL, 8);
    wr(A_IEN, 1);
    wr(A_PSC, 16'h1234);
    wr(A_RELOAD, 16'hBEEF);
    @(negedge clk);
    rd(A_CTRL, v);   chk("R11 ctrl readback", v, 8);
    rd(A_IEN, v);    chk("R11 ien readback", v, 1);
    rd(A_PSC, v);    chk("R11 psc readback", v, 16'h1234);
    rd(A_RELOAD, v); chk("R11 reload readback", v, 16'hBEEF);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v);  chk("R10 count idle while run=0", v, 0);
  endtask

  task automatic t_up_prescaled();
    int per, mx;
    start(2, 4, 0, 0);
    measure_up(per, mx);
    chk("R1 up period psc=2 reload=4", per, 15);
    chk("R2 up peak", mx, 4);
    start(0, 6, 0, 0);
    measure_up(per, mx);
    chk("R1 up period psc=0 reload=6", per, 7);
    chk("R2 up peak reload=6", mx, 6);
    start(0, 3, 6, 0);
    measure_up(per, mx);
    chk("R4 mode 6 behaves as up", per, 4);
  endtask

  task automatic t_down();
    int per, bad;
    bad = 0;
    per = 0;
    start(1, 3, 1, 0);
    repeat (12) samp();
    for (int i = 0; i < 60; i++) begin
      samp();
      if (c == 3 && prev == 0) break;
    end
    for (int i = 0; i < 60; i++) begin
      samp();
      per++;
      if (c != prev && !(c == prev - 1 || (prev == 0 && c == 3))) bad++;
      if (c == 3 && prev == 0) break;
    end
    chk("R3 down period psc=1 reload=3", per, 8);
    chk("R3 down step order", bad, 0);
  endtask

  // returns the count seen right after the interrupt request rose
  task automatic next_event_cnt(output int at);
    at = -1;
    for (int i = 0; i < 40; i++) begin
      samp();
      if (irq) begin
        at = c;
        break;
      end
    end
    wr_now(A_STATUS, 0);
  endtask

  task automatic clear_quiet();
    for (int i = 0; i < 4; i++) begin
      wr(A_STATUS, 0);
      samp();
      if (!irq) break;
    end
  endtask

  task automatic t_center();
    int a, b;
    start(0, 3, 3, 1);
    repeat (12) samp();
    clear_quiet();
    next_event_cnt(a);
    chk("R4 center top-only event count", a, 2);
    next_event_cnt(a);
    chk("R4 center top-only again", a, 2);

    start(0, 3, 2, 1);
    repeat (12) samp();
    clear_quiet();
    next_event_cnt(a);
    chk("R4 center bottom-only event count", a, 1);

    start(0, 3, 4, 1);
    repeat (12) samp();
    clear_quiet();
    next_event_cnt(a);
    next_event_cnt(b);
    chk("R4 center both: events sum", a + b, 3);
    chk("R4 center both: events alternate", int'(a != b), 1);
  endtask

  task automatic t_reload_shadow();
    int v, mx, per;
    start(0, 9, 0, 0);
    repeat (12) samp();
    for (int i = 0; i < 40; i++) begin
      samp();
      if (c == 2) break;
    end
    wr(A_RELOAD, 3);
    @(negedge clk);
    rd(A_RELOAD, v);
    chk("R5 reload readback immediate", v, 3);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      samp();
      if (c > mx) mx = c;
      if (c == 0 && prev != 0) break;
    end
    chk("R5 old reload still governs", mx, 9);
    measure_up(per, mx);
    chk("R5 new reload after update", mx, 3);
  endtask

  task automatic t_psc_shadow();
    int per, mx, v;
    start(0, 3, 0, 0);
    measure_up(per, mx);
    chk("R6 period before psc write", per, 4);
    for (int i = 0; i < 20; i++) begin
      samp();
      if (c == 1) break;
    end
    wr(A_PSC, 1);
    samp();
    chk("R6 old psc still active", c, 3);
    rd(A_PSC, v);
    chk("R6 psc readback", v, 1);
    measure_up(per, mx);
    chk("R6 period after update", per, 8);
  endtask

  task automatic t_flag_collide();
    int v;
    start(0, 4, 0, 1);
    repeat (12) samp();
    for (int i = 0; i < 20; i++) begin
      samp();
      if (c == 1) break;
    end
    wr_now(A_STATUS, 0);
    samp();
    chk("R7 clear write lowers irq", int'(irq), 0);
    chk("R7 count after clear", c, 2);
    wr_now(A_STATUS, 1);
    samp();
    chk("R7 writing 1 does not set", int'(irq), 0);
    samp();
    chk("R8 count before collision", c, 4);
    wr_now(A_STATUS, 0);
    samp();
    chk("R8 wrap in collision cycle", c, 0);
    chk("R8 set wins over clear", int'(irq), 1);
    wr_now(A_IEN, 0);
    samp();
    chk("R9 irq low with enable 0", int'(irq), 0);
    rd(A_STATUS, v);
    chk("R9 flag still set", v, 1);
    wr(A_IEN, 1);
    samp();
    chk("R9 irq back with enable 1", int'(irq), 1);
  endtask

  task automatic t_hold();
    int held, moved;
    start(1, 9, 0, 0);
    repeat (6) samp();
    for (int i = 0; i < 40; i++) begin
      samp();
      if (c == 5) break;
    end
    wr(A_CTRL, 0);
    samp();
    held = c;
    moved = 0;
    for (int i = 0; i < 10; i++) begin
      samp();
      if (c != held) moved++;
    end
    chk("R10 count held while stopped", moved, 0);
    wr(A_CTRL, 1);
    repeat (4) samp();
    chk("R10 count resumes", int'(c != held), 1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_up_prescaled();
    t_down();
    t_center();
    t_reload_shadow();
    t_psc_shadow();
    t_flag_collide();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule